// File: doc/BRIEF.md
# Register Mask-Rotate-Combine Unit

This block updates one entry of a small local register file in a single read-modify-write step. A command names a destination register, two source operands, a 5-bit rotate amount and a combine mode. The destination's current value is ANDed with the first source. That masked value is rotated left, so bits leaving the top re-enter at the bottom. The rotated value is then either added to the second source or ORed with it, and the result is written back to the destination.

Each of the two sources is chosen on its own, either from a register index or from an immediate carried in the command. The unit takes commands over a valid/ready handshake and accepts at most one command every two cycles. It reports each write-back on a write-back port with a one-cycle done strobe.

Top module: `rmw_rotate_unit`

## Requirements
- R1: After reset, `cmd_ready_o` is 1, `done_o` is 0, and all 16 registers hold 0.
- R2: When `cmd_add_i` is 1, the new destination value is rotl(dst AND src0, rot) + src1, wrapping modulo 2^32.
- R3: When `cmd_add_i` is 0, the new destination value is rotl(dst AND src0, rot) OR src1.
- R4: The rotation is circular: a bit shifted out of bit 31 reappears at bit 0 (for example, 0x80000001 rotated by 1 gives 0x00000003).
- R5: Source n is the immediate `cmd_srcN_imm_i` when `cmd_srcN_is_imm_i` is 1, and the register at `cmd_srcN_idx_i` when it is 0. The field that is not selected has no effect.
- R6: A source whose register index equals the destination index supplies the destination's value from before the update.
- R7: A rotate amount of 0 leaves the masked value unrotated.
- R8: A command accepted at clock edge N drives `cmd_ready_o` low until edge N+1. It raises `done_o` and `wb_en_o` for exactly the one cycle between edges N+1 and N+2.
- R9: `wb_idx_o` and `wb_data_o` show the destination index and the new value while `done_o` is high. From edge N+1 onward, the register file holds the new value, and any later command reads it.
- R10: While `cmd_valid_i` is low, no write-back occurs and the register contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Unit can accept a command |
| cmd_dst_i | input | 4 | Destination register index |
| cmd_src0_is_imm_i | input | 1 | 1: source 0 is the immediate, 0: source 0 is a register |
| cmd_src0_idx_i | input | 4 | Source 0 register index |
| cmd_src0_imm_i | input | 32 | Source 0 immediate |
| cmd_src1_is_imm_i | input | 1 | 1: source 1 is the immediate, 0: source 1 is a register |
| cmd_src1_idx_i | input | 4 | Source 1 register index |
| cmd_src1_imm_i | input | 32 | Source 1 immediate |
| cmd_rot_i | input | 5 | Left-rotate amount |
| cmd_add_i | input | 1 | 1: add source 1, 0: OR source 1 |
| wb_en_o | output | 1 | Write-back valid |
| wb_idx_o | output | 4 | Written register index |
| wb_data_o | output | 32 | Written value |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A command accepted at edge N is first visible at the ports as `cmd_ready_o` low just after that edge. Its result appears on `done_o`, `wb_idx_o` and `wb_data_o` after edge N+1 and is gone after edge N+2. The bench drives inputs on falling edges and holds valid for exactly one rising edge. It checks ready on the falling edge after acceptance and the write-back on the falling edge after that. Register contents are read back through the unit itself, using an AND with all ones, a rotate of 0 and an OR with 0. The bench's expected values come from a shadow register array, updated with a bit-by-bit rotate.

// File: rtl/rmw_rotate_pkg.sv
package rmw_rotate_pkg;
  typedef enum logic {
    COMB_OR  = 1'b0,
    COMB_ADD = 1'b1
  } comb_e;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned NUM_RD  = NUM_SRC + 1;
endpackage

// File: rtl/rmw_regfile.sv
module rmw_regfile #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned NUM_RD   = 3,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [DATA_W-1:0]              wr_data_i
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_data_o[g] = mem_q[rd_idx_i[g]];
  end
endmodule

// File: rtl/rmw_opsel.sv
module rmw_opsel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] op_o
);
  assign op_o = use_imm_i ? imm_i : reg_i;
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_rotate_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic [DATA_W-1:0] addend_i,
  input  comb_e             mode_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0]   masked;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   rotated;

  assign masked  = dst_i & mask_i;
  // upper half of the doubled word shifted left is the circular rotate
  assign dbl     = {masked, masked} << rot_i;
  assign rotated = dbl[2*DATA_W-1:DATA_W];

  always_comb begin
    unique case (mode_i)
      COMB_ADD: res_o = rotated + addend_i;
      default:  res_o = rotated | addend_i;
    endcase
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_rotate_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ROT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [IDX_W-1:0]  dst_idx_i,
  input  logic [DATA_W-1:0] dst_val_i,
  input  logic [DATA_W-1:0] src0_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  comb_e             mode_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [DATA_W-1:0] dst_val_o,
  output logic [DATA_W-1:0] src0_o,
  output logic [DATA_W-1:0] src1_o,
  output logic [ROT_W-1:0]  rot_o,
  output comb_e             mode_o,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      dst_idx_o <= '0;
      dst_val_o <= '0;
      src0_o    <= '0;
      src1_o    <= '0;
      rot_o     <= '0;
      mode_o    <= COMB_OR;
    end else if (accept_i) begin
      busy_o    <= 1'b1;
      dst_idx_o <= dst_idx_i;
      dst_val_o <= dst_val_i;
      src0_o    <= src0_i;
      src1_o    <= src1_i;
      rot_o     <= rot_i;
      mode_o    <= mode_i;
    end else begin
      busy_o    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      wb_en_o <= busy_o;
      if (busy_o) begin
        wb_idx_o  <= dst_idx_o;
        wb_data_o <= result_i;
      end
    end
  end
endmodule

// File: rtl/rmw_rotate_unit.sv
module rmw_rotate_unit
  import rmw_rotate_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS),
  parameter int unsigned ROT_W    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [IDX_W-1:0]  cmd_dst_i,
  input  logic              cmd_src0_is_imm_i,
  input  logic [IDX_W-1:0]  cmd_src0_idx_i,
  input  logic [DATA_W-1:0] cmd_src0_imm_i,
  input  logic              cmd_src1_is_imm_i,
  input  logic [IDX_W-1:0]  cmd_src1_idx_i,
  input  logic [DATA_W-1:0] cmd_src1_imm_i,
  input  logic [ROT_W-1:0]  cmd_rot_i,
  input  logic              cmd_add_i,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              done_o
);
  logic                          accept, busy;
  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
  logic [NUM_SRC-1:0]            src_is_imm;
  logic [NUM_SRC-1:0][DATA_W-1:0] src_imm, src_val;
  logic [IDX_W-1:0]              lat_idx;
  logic [DATA_W-1:0]             lat_dst, lat_s0, lat_s1, result;
  logic [ROT_W-1:0]              lat_rot;
  comb_e                         lat_mode, cmd_mode;

  assign cmd_ready_o = !busy;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign cmd_mode    = cmd_add_i ? COMB_ADD : COMB_OR;

  // read port 0 = destination, ports 1.. = sources
  assign rd_idx[0]  = cmd_dst_i;
  assign rd_idx[1]  = cmd_src0_idx_i;
  assign rd_idx[2]  = cmd_src1_idx_i;
  assign src_is_imm = {cmd_src1_is_imm_i, cmd_src0_is_imm_i};
  assign src_imm    = {cmd_src1_imm_i, cmd_src0_imm_i};

  rmw_regfile #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD), .IDX_W(IDX_W)
  ) u_rf (
    .clk_i, .rst_ni,
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .we_i      (busy),
    .wr_idx_i  (lat_idx),
    .wr_data_i (result)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    rmw_opsel #(.DATA_W(DATA_W)) u_sel (
      .use_imm_i (src_is_imm[g]),
      .imm_i     (src_imm[g]),
      .reg_i     (rd_data[g+1]),
      .op_o      (src_val[g])
    );
  end

  rmw_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ROT_W(ROT_W)) u_seq (
    .clk_i, .rst_ni,
    .accept_i  (accept),
    .dst_idx_i (cmd_dst_i),
    .dst_val_i (rd_data[0]),
    .src0_i    (src_val[0]),
    .src1_i    (src_val[1]),
    .rot_i     (cmd_rot_i),
    .mode_i    (cmd_mode),
    .result_i  (result),
    .busy_o    (busy),
    .dst_idx_o (lat_idx),
    .dst_val_o (lat_dst),
    .src0_o    (lat_s0),
    .src1_o    (lat_s1),
    .rot_o     (lat_rot),
    .mode_o    (lat_mode),
    .wb_en_o   (wb_en_o),
    .wb_idx_o  (wb_idx_o),
    .wb_data_o (wb_data_o)
  );

  rmw_alu #(.DATA_W(DATA_W), .ROT_W(ROT_W)) u_alu (
    .dst_i    (lat_dst),
    .mask_i   (lat_s0),
    .rot_i    (lat_rot),
    .addend_i (lat_s1),
    .mode_i   (lat_mode),
    .res_o    (result)
  );

  assign done_o = wb_en_o;
endmodule

// File: rtl/rmw_rotate_unit_chk.sv
module rmw_rotate_unit_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [IDX_W-1:0] cmd_dst_i,
  input logic             done_o,
  input logic [IDX_W-1:0] wb_idx_o
);
  logic accept;
  assign accept = cmd_valid_i && cmd_ready_o;

  a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !cmd_ready_o);

  a_r8_done_two_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##1 done_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_ready_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);

  a_r10_done_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(accept, 2));

  a_r9_wb_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> wb_idx_o == $past(cmd_dst_i, 2));
endmodule

bind rmw_rotate_unit rmw_rotate_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_dst_i   (cmd_dst_i),
  .done_o      (done_o),
  .wb_idx_o    (wb_idx_o)
);

// File: tb/rmw_rotate_unit_tb_top.sv
`timescale 1ns/1ps
module rmw_rotate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_dst = '0;
  logic        s0_imm = 1'b0, s1_imm = 1'b0;
  logic [3:0]  s0_idx = '0, s1_idx = '0;
  logic [31:0] s0_val = '0, s1_val = '0;
  logic [4:0]  cmd_rot = '0;
  logic        cmd_add = 1'b0;
  logic        wb_en, done;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  rmw_rotate_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_dst_i(cmd_dst),
    .cmd_src0_is_imm_i(s0_imm), .cmd_src0_idx_i(s0_idx), .cmd_src0_imm_i(s0_val),
    .cmd_src1_is_imm_i(s1_imm), .cmd_src1_idx_i(s1_idx), .cmd_src1_imm_i(s1_val),
    .cmd_rot_i(cmd_rot), .cmd_add_i(cmd_add),
    .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl_ref(input logic [31:0] x, input int r);
    logic [31:0] y = x;
    for (int i = 0; i < r; i++) y = {y[30:0], y[31]};
    return y;
  endfunction

  task automatic run_op(input string req, input logic [3:0] d,
                        input logic i0, input logic [3:0] x0, input logic [31:0] v0,
                        input logic i1, input logic [3:0] x1, input logic [31:0] v1,
                        input logic [4:0] r, input logic add);
    logic [31:0] a0, a1, m, exp;
    a0  = i0 ? v0 : model[x0];
    a1  = i1 ? v1 : model[x1];
    m   = rotl_ref(model[d] & a0, int'(r));
    exp = add ? m + a1 : m | a1;
    @(negedge clk);
    cmd_dst = d; s0_imm = i0; s0_idx = x0; s0_val = v0;
    s1_imm = i1; s1_idx = x1; s1_val = v1; cmd_rot = r; cmd_add = add;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 ready low while busy", {31'd0, cmd_ready}, 32'd0);
    check("R8 no early done", {31'd0, done}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 done strobe", {31'd0, done}, 32'd1);
    check("R8 wb_en", {31'd0, wb_en}, 32'd1);
    check("R9 wb_idx", {28'd0, wb_idx}, {28'd0, d});
    check(req, wb_data, exp);
    model[d] = exp;
  endtask

  // read back register d without changing it: AND all ones, rotate 0, OR 0
  task automatic read_back(input string req, input logic [3:0] d);
    run_op(req, d, 1'b1, 4'd0, 32'hFFFF_FFFF, 1'b1, 4'd0, 32'd0, 5'd0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
    check("R1 done after reset", {31'd0, done}, 32'd0);
    for (int i = 0; i < 16; i++) read_back("R1 reset value", 4'(i));

    // load every register: mask with 0, OR in the value
    for (int i = 0; i < 16; i++)
      run_op("R3 load", 4'(i), 1'b1, 4'd0, 32'd0, 1'b1, 4'd0,
             (32'h9E37_79B9 * 32'(i + 1)) ^ (32'(i) << 28), 5'd0, 1'b0);

    // circular rotate
    run_op("R4 setup", 4'd3, 1'b1, 4'd0, 32'd0, 1'b1, 4'd0, 32'h8000_0001, 5'd0, 1'b0);
    run_op("R4 wrap", 4'd3, 1'b1, 4'd0, 32'hFFFF_FFFF, 1'b1, 4'd0, 32'd0, 5'd1, 1'b0);
    check("R4 wrap value", model[3], 32'h0000_0003);
    run_op("R4 wrap 31", 4'd3, 1'b1, 4'd0, 32'hFFFF_FFFF, 1'b1, 4'd0, 32'd0, 5'd31, 1'b0);
    check("R4 wrap 31 value", model[3], 32'h8000_0001);

    // add wraps modulo 2^32
    run_op("R2 setup", 4'd4, 1'b1, 4'd0, 32'd0, 1'b1, 4'd0, 32'hFFFF_FFF0, 5'd0, 1'b0);
    run_op("R2 wrap add", 4'd4, 1'b1, 4'd0, 32'hFFFF_FFFF, 1'b1, 4'd0, 32'h0000_0020, 5'd0, 1'b1);
    check("R2 wrap add value", model[4], 32'h0000_0010);

    // source selection: unused field must not matter
    run_op("R5 reg src0, garbage imm", 4'd5, 1'b0, 4'd9, 32'h0000_0000, 1'b1, 4'd2, 32'h0000_0100, 5'd4, 1'b1);
    run_op("R5 imm src1, idx points elsewhere", 4'd6, 1'b1, 4'd11, 32'h0FF0_0FF0, 1'b1, 4'd12, 32'h1, 5'd8, 1'b0);
    run_op("R5 both regs", 4'd7, 1'b0, 4'd13, 32'h0, 1'b0, 4'd14, 32'h0, 5'd13, 1'b1);

    // sources aliasing the destination
    run_op("R6 src0=src1=dst add", 4'd8, 1'b0, 4'd8, 32'h0, 1'b0, 4'd8, 32'h0, 5'd7, 1'b1);
    run_op("R6 src1=dst or", 4'd9, 1'b1, 4'd0, 32'hF0F0_F0F0, 1'b0, 4'd9, 32'h0, 5'd3, 1'b0);

    // rotate 0
    run_op("R7 rot zero", 4'd10, 1'b1, 4'd0, 32'h00FF_FF00, 1'b1, 4'd0, 32'h0, 5'd0, 1'b0);

    // sweep all rotate amounts in both modes with mixed sources
    for (int r = 0; r < 32; r++) begin
      for (int md = 0; md < 2; md++) begin
        string tag;
        tag = (r == 0) ? "R7 sweep" : (md == 1 ? "R2 sweep" : "R3 sweep");
        run_op(tag, 4'(r + md),
               (r % 3) == 0, 4'((r * 5 + 1) % 16), 32'hF0F0_1234 ^ 32'(r),
               (r % 2) == 0, 4'((r + 7) % 16), 32'(r) * 32'h0101_0101,
               5'(r), md[0]);
      end
    end

    // idle: no write-back, registers untouched
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check("R10 idle no done", {31'd0, done}, 32'd0);
    end
    for (int i = 0; i < 16; i++) read_back("R10 R9 readback", 4'(i));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule